// File: doc/BRIEF.md
# Hierarchical Register RAM

This block is a word-addressable memory made only of clocked 16-bit word registers. The registers are grouped in a recursive tree. A base bank holds eight words. Each level above it groups eight copies of the level below. The outermost level may use a smaller group, such as four, so that the total lands exactly on 16K words. The incoming word goes to every register at once. A decode of the address, spread over the levels, lets only the addressed register load it. A matching tree of multiplexers returns the addressed word.

The memory is used wherever a small, fully flop-based store with a combinational read port is wanted. The caller presents an address and reads the word in the same cycle. To write, it raises the load strobe for one rising clock edge. The number of levels and the outer group size are parameters. They set the word count and the address width.

Top module: `ram_hier_top`

## Requirements
- R1: Every word stores all 16 data bits independently, so the patterns 16'hFFFF, 16'h0000 and 16'h5AA5 each read back exactly as written.
- R2: When `wr_load` is 1 at a rising edge of `clk`, the word at `addr` takes the value of `wr_data`.
- R3: A write changes only the addressed word. Every other word keeps its value.
- R4: When `wr_load` is 0 at a rising edge, no word changes, whatever `wr_data` and `addr` hold.
- R5: `rd_data` shows the contents of the word at `addr` combinationally. An address change is seen on `rd_data` before the next clock edge.
- R6: A write shows on `rd_data` only after the edge that performs it. While `wr_load` is high before that edge, `rd_data` still shows the old contents.
- R7: The address is split into fields. The lowest 3 bits pick a word inside a base bank of eight. Each next 3-bit field picks one of eight sub-banks. The top `$clog2(TOP_GROUP)` bits pick the outermost group. The first and last words of neighbouring banks (for example addresses 7 and 8, 55 and 56) are separate storage.
- R8: The memory holds `8**(LEVELS-1) * TOP_GROUP` distinct words, addressed by `3*(LEVELS-1) + $clog2(TOP_GROUP)` bits. With the defaults this is 64 words and 6 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes happen on its rising edge |
| wr_data | input | 16 | Word offered to the addressed location |
| addr | input | ADDR_W | Word address, hierarchical fields as in R7 |
| wr_load | input | 1 | Write strobe for the addressed word |
| rd_data | output | 16 | Contents of the word at `addr`, combinational |

## Verification
A wrong load decode at any level shows up on the read port in one of two ways. It appears at once as a word that failed to take its value when read back after the edge. It can also appear later, as a word that changed when it was never addressed, and only a read of that exact word reveals it. For that reason every location is read back after each write pass. A wrong select field in the read multiplexers shows up with no delay: the output moves to a neighbour's value when the address is changed between edges. The first and last words of each sub-bank sit at the field boundaries, where a swapped or shifted field shows up first.

// File: rtl/ram_hier_pkg.sv
package ram_hier_pkg;

  localparam int WORD_W     = 16;
  localparam int BANK_WAYS  = 8;
  localparam int BANK_SEL_W = $clog2(BANK_WAYS);

  // Address width of a tree with the given number of levels whose
  // outermost level groups top_group children.
  function automatic int tree_addr_w(input int levels, input int top_group);
    return BANK_SEL_W * (levels - 1) + $clog2(top_group);
  endfunction

  function automatic int tree_words(input int levels, input int top_group);
    return (BANK_WAYS ** (levels - 1)) * top_group;
  endfunction

endpackage

// File: rtl/ram_bit_cell.sv
module ram_bit_cell (
  input  logic clk,
  input  logic d,
  input  logic load,
  output logic q
);

  always_ff @(posedge clk) begin
    if (load) q <= d;
  end

endmodule

// File: rtl/ram_word_reg.sv
module ram_word_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  input  logic             load,
  output logic [WIDTH-1:0] q
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    ram_bit_cell cell_u (
      .clk  (clk),
      .d    (d[b]),
      .load (load),
      .q    (q[b])
    );
  end

endmodule

// File: rtl/ram_sel_demux.sv
module ram_sel_demux #(
  parameter int WAYS = 8,
  localparam int SEL_W = $clog2(WAYS)
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             en,
  output logic [WAYS-1:0]  way_en
);

  for (genvar i = 0; i < WAYS; i++) begin : g_way
    assign way_en[i] = en && (sel == SEL_W'(i));
  end

endmodule

// File: rtl/ram_sel_mux.sv
module ram_sel_mux #(
  parameter int WAYS  = 8,
  parameter int WIDTH = 16,
  localparam int SEL_W = $clog2(WAYS)
) (
  input  logic [SEL_W-1:0]           sel,
  input  logic [WAYS-1:0][WIDTH-1:0] ways,
  output logic [WIDTH-1:0]           out
);

  always_comb begin
    out = ways[sel];
  end

endmodule

// File: rtl/ram_level.sv
module ram_level
  import ram_hier_pkg::*;
#(
  parameter int LEVEL = 2,
  parameter int GROUP = 8,
  localparam int SEL_W = $clog2(GROUP),
  localparam int SUB_W = BANK_SEL_W * (LEVEL - 1),
  localparam int AW    = SEL_W + SUB_W
) (
  input  logic              clk,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [AW-1:0]     addr,
  input  logic              wr_load,
  output logic [WORD_W-1:0] rd_data
);

  logic [GROUP-1:0]             way_en;
  logic [GROUP-1:0][WORD_W-1:0] way_rd;
  logic [SEL_W-1:0]             way_sel;

  // The upper field of this level's address picks the child.
  assign way_sel = addr[AW-1:SUB_W];

  ram_sel_demux #(.WAYS(GROUP)) wr_dmx_u (
    .sel    (way_sel),
    .en     (wr_load),
    .way_en (way_en)
  );

  if (LEVEL == 1) begin : g_base
    for (genvar w = 0; w < GROUP; w++) begin : g_word
      ram_word_reg #(.WIDTH(WORD_W)) word_u (
        .clk  (clk),
        .d    (wr_data),
        .load (way_en[w]),
        .q    (way_rd[w])
      );
    end
  end else begin : g_tree
    logic [SUB_W-1:0] sub_addr;
    assign sub_addr = addr[SUB_W-1:0];
    for (genvar s = 0; s < GROUP; s++) begin : g_sub
      ram_level #(.LEVEL(LEVEL - 1), .GROUP(BANK_WAYS)) sub_u (
        .clk     (clk),
        .wr_data (wr_data),
        .addr    (sub_addr),
        .wr_load (way_en[s]),
        .rd_data (way_rd[s])
      );
    end
  end

  ram_sel_mux #(.WAYS(GROUP), .WIDTH(WORD_W)) rd_mux_u (
    .sel  (way_sel),
    .ways (way_rd),
    .out  (rd_data)
  );

endmodule

// File: rtl/ram_hier_top.sv
module ram_hier_top
  import ram_hier_pkg::*;
#(
  parameter int LEVELS    = 2,
  parameter int TOP_GROUP = 8,
  localparam int ADDR_W   = tree_addr_w(LEVELS, TOP_GROUP)
) (
  input  logic              clk,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_load,
  output logic [WORD_W-1:0] rd_data
);

  ram_level #(.LEVEL(LEVELS), .GROUP(TOP_GROUP)) root_u (
    .clk     (clk),
    .wr_data (wr_data),
    .addr    (addr),
    .wr_load (wr_load),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/ram_hier_chk.sv
module ram_hier_chk #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic [WORD_W-1:0] wr_data,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_load,
  input logic [WORD_W-1:0] rd_data
);

  logic              armed = 1'b0;
  logic              watch_valid = 1'b0;
  logic [ADDR_W-1:0] watch_addr = '0;
  logic [WORD_W-1:0] watch_data = '0;

  always_ff @(posedge clk) begin
    armed <= 1'b1;
    if (wr_load) begin
      watch_valid <= 1'b1;
      watch_addr  <= addr;
      watch_data  <= wr_data;
    end
  end

  // R2
  write_visible_chk: assert property (@(posedge clk) disable iff (!armed)
    wr_load |=> ((addr != $past(addr)) || (rd_data == $past(wr_data))));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!armed)
    !wr_load |=> ((addr != $past(addr)) || $stable(rd_data)));

  // R3
  last_write_kept_chk: assert property (@(posedge clk) disable iff (!armed)
    (watch_valid && (addr == watch_addr)) |-> (rd_data == watch_data));

  // R1
  written_known_chk: assert property (@(posedge clk) disable iff (!armed)
    (watch_valid && (addr == watch_addr) && !$isunknown(watch_data))
      |-> !$isunknown(rd_data));

endmodule

bind ram_hier_top ram_hier_chk #(
  .ADDR_W (ADDR_W),
  .WORD_W (ram_hier_pkg::WORD_W)
) chk_u (
  .clk     (clk),
  .wr_data (wr_data),
  .addr    (addr),
  .wr_load (wr_load),
  .rd_data (rd_data)
);

// File: tb/ram_hier_top_test.sv
module ram_hier_top_test;

  localparam int LEVELS    = 2;
  localparam int TOP_GROUP = 8;
  localparam int AW        = 3 * (LEVELS - 1) + $clog2(TOP_GROUP);
  localparam int DEPTH     = (8 ** (LEVELS - 1)) * TOP_GROUP;
  localparam int NVEC      = 12;

  // {load, addr, data}
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b1, 6'd0,  16'h1001},
    {1'b1, 6'd7,  16'h1707},
    {1'b1, 6'd8,  16'h2008},
    {1'b1, 6'd15, 16'h2F0F},
    {1'b0, 6'd5,  16'hDEAD},
    {1'b1, 6'd55, 16'h7737},
    {1'b1, 6'd56, 16'h8038},
    {1'b1, 6'd63, 16'h8F3F},
    {1'b0, 6'd40, 16'hBEEF},
    {1'b1, 6'd31, 16'h4F1F},
    {1'b1, 6'd32, 16'h5020},
    {1'b0, 6'd63, 16'h0BAD}
  };

  logic          clk = 1'b0;
  logic [15:0]   wr_data = '0;
  logic [AW-1:0] addr = '0;
  logic          wr_load = 1'b0;
  logic [15:0]   rd_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [15:0] model [DEPTH];

  always #2 clk = ~clk;

  ram_hier_top #(.LEVELS(LEVELS), .TOP_GROUP(TOP_GROUP)) uut (
    .clk     (clk),
    .wr_data (wr_data),
    .addr    (addr),
    .wr_load (wr_load),
    .rd_data (rd_data)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", req, addr, act, exp);
    end
  endtask

  task automatic do_write(input int a, input logic [15:0] d);
    @(negedge clk);
    addr = AW'(a); wr_data = d; wr_load = 1'b1;
    @(negedge clk);
    wr_load = 1'b0;
    model[a] = d;
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      addr = AW'(a); wr_load = 1'b0;
      #1 check(req, rd_data, model[a]);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);

    // R8: fill every location, then read all back.
    for (int a = 0; a < DEPTH; a++) do_write(a, 16'hA000 ^ 16'(a * 16'h0123));
    read_all("R8");

    // Table walk: R2/R4 after the edge, R6/R5 before it.
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      addr = VEC[i][21:16]; wr_data = VEC[i][15:0]; wr_load = VEC[i][22];
      #1 check(VEC[i][22] ? "R6" : "R5", rd_data, model[VEC[i][21:16]]);
      @(posedge clk);
      if (VEC[i][22]) model[VEC[i][21:16]] = VEC[i][15:0];
      @(negedge clk);
      wr_load = 1'b0;
      #1 check(VEC[i][22] ? "R2" : "R4", rd_data, model[VEC[i][21:16]]);
    end
    // R3 and R7: bank-edge writes left every other word alone.
    read_all("R3_R7");

    // R1: full-width patterns.
    do_write(9, 16'hFFFF);
    do_write(10, 16'h0000);
    do_write(11, 16'h5AA5);
    @(negedge clk); addr = 6'd9;  #1 check("R1", rd_data, 16'hFFFF);
    addr = 6'd10; #1 check("R1", rd_data, 16'h0000);
    addr = 6'd11; #1 check("R1", rd_data, 16'h5AA5);

    // R5: address changes between edges are seen without a clock.
    @(posedge clk); #0.5;
    addr = 6'd56; #0.5 check("R5", rd_data, model[56]);
    addr = 6'd55; #0.5 check("R5", rd_data, model[55]);

    // R4: several idle edges with busy inputs change nothing.
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      addr = AW'(i * 13); wr_data = 16'hEEEE; wr_load = 1'b0;
    end
    read_all("R4");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule